// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer

This block sits between a synchronous request port and an external 8192 x 8 asynchronous static RAM. That RAM is selected by two chip enables of opposite polarity and is controlled by a write strobe and an output enable. The sequencer takes one read or write at a time over a valid/ready handshake with a 13-bit address and a byte of data. It then steps the memory strobes through fixed phases. Each phase lasts a whole number of system-clock cycles. That number is computed at elaboration as the ceiling of a nanosecond minimum divided by the clock period parameter, and is never less than one cycle. Read data comes back on a one-cycle valid pulse.

The state machine has six states. IDLE accepts requests. A write passes through WR_SETUP (chip selected, address applied, write strobe high), WR_PULSE (write strobe low, bus driven) and WR_HOLD (strobe released, data and address still held), then returns to IDLE. A read passes through RD_ACCESS (chip selected, output enable low, held for the longest access time) and then RD_TURN (everything released, bus idle), then returns to IDLE. The transitions are: IDLE to WR_SETUP on an accepted write, IDLE to RD_ACCESS on an accepted read, and each later state to its successor when its phase counter expires. The data bus is split into an output byte, a drive enable and an input byte, and the pad is built outside the block.

With a 125 MHz clock, a write takes 4 cycles with a 2-cycle strobe. A read holds the output enable for 4 cycles and then spends 2 turnaround cycles.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: After reset, ready is 1, the active-low select is 1, the active-high select is 0, the write strobe and the output enable (both active low) are 1, the drive enable is 0 and read-valid is 0.
- R2: A request is taken on a rising edge where valid and ready are both 1. Ready is 0 from the next cycle until the operation ends. At 8 ns it returns after 4 cycles for a write and after 6 cycles for a read.
- R3: The memory is selected (active-low select 0 and active-high select 1, always together) only while an operation is in progress. Whenever ready is 1 the memory is deselected.
- R4: The write strobe is low only while the memory is selected and the output enable is high. It stays low for at least ceil(12 ns / period) cycles and for at least 12 ns.
- R5: The drive enable is 1 for the whole write-strobe-low window and still 1 in the cycle the strobe rises. It rises at least 10 ns before the strobe ends, is never 1 while the output enable is low, and never overlaps the memory driving the bus.
- R6: The address and write byte do not change while the memory is selected. The address and the selection are valid for at least 20 ns before the write strobe rises.
- R7: A read holds the output enable low with the memory selected for max(ceil(25 ns), ceil(9 ns)) cycles. The input byte is captured on the edge that ends that window, and read-valid is a one-cycle pulse visible from that edge.
- R8: After a read, at least ceil(9 ns / period) cycles pass with the memory deselected and the drive enable 0 before another operation starts.
- R9: Every selection window lasts at least 25 ns.
- R10: A read returns the byte last written to that address, across the full address range and the extreme data values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Word address |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | One-cycle pulse with read byte |
| rd_data | output | 8 | Captured read byte |
| mem_addr | output | 13 | Memory address bus |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel_hi | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | 8 | Byte driven toward the memory |
| mem_dq_drv | output | 1 | Bus drive enable |
| mem_dq_in | input | 8 | Byte read from the memory bus |

## Verification
The hardest behaviour to exercise is a timing violation that still returns plausible data: a read captured before the access time has elapsed, or a write whose data or address setup is short. The bench holds a behavioural memory that timestamps every strobe, address and drive-enable change on a 1 ns grid. Until the access time has elapsed, this memory drives the inverted stored byte, and it commits a write only at the strobe's rising edge, after checking pulse width, setup and contention. Reads that land directly on a write, writes that follow a read with no gap, and requests held on valid while the block is busy all come from a seeded random mix over a small hot address set plus the extreme addresses.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD,
        ST_RD_ACCESS,
        ST_RD_TURN
    } ctl_state_e;

    // Cycles needed to cover t_ps at a clock period of clk_ps, never below one.
    function automatic int ncyc(input int t_ps, input int clk_ps);
        int n;
        n = (t_ps + clk_ps - 1) / clk_ps;
        return (n < 1) ? 1 : n;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_rd_capture.sv
`timescale 1ns/1ps
module sram_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [DATA_W-1:0] din,
    output logic              valid,
    output logic [DATA_W-1:0] data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid <= 1'b0;
            data  <= '0;
        end else begin
            valid <= strobe;
            if (strobe)
                data <= din;
        end
    end
endmodule

// File: rtl/sram_strobe_ctrl.sv
`timescale 1ns/1ps
module sram_strobe_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int DATA_W    = 8,
    parameter int CLK_PS    = 8000,
    parameter int T_WP_PS   = 12000,
    parameter int T_DW_PS   = 10000,
    parameter int T_AW_PS   = 20000,
    parameter int T_WC_PS   = 25000,
    parameter int T_RC_PS   = 25000,
    parameter int T_AA_PS   = 25000,
    parameter int T_OE_PS   = 9000,
    parameter int T_OHZ_PS  = 9000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel_n,
    output logic              mem_sel_hi,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_drv,
    input  logic [DATA_W-1:0] mem_dq_in
);
    // Phase lengths in clock cycles.
    localparam int N_SU  = 1;
    localparam int N_WP  = imax(imax(ncyc(T_WP_PS, CLK_PS), ncyc(T_DW_PS, CLK_PS)),
                                imax(ncyc(T_AW_PS, CLK_PS) - N_SU, 1));
    localparam int N_WH  = imax(1, ncyc(T_WC_PS, CLK_PS) - N_SU - N_WP);
    localparam int N_RD  = imax(imax(ncyc(T_RC_PS, CLK_PS), ncyc(T_AA_PS, CLK_PS)),
                                ncyc(T_OE_PS, CLK_PS));
    localparam int N_TA  = ncyc(T_OHZ_PS, CLK_PS);
    localparam int N_MAX = imax(imax(N_WP, N_WH), imax(N_RD, N_TA));
    localparam int CNT_W = $clog2(N_MAX + 1);

    ctl_state_e        st_q, st_d;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_done;
    logic              accept;
    logic              nxt_sel, nxt_we, nxt_oe, nxt_drv;

    assign req_ready = (st_q == ST_IDLE);
    assign accept    = req_valid && req_ready;

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    sram_rd_capture #(.DATA_W(DATA_W)) u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe ((st_q == ST_RD_ACCESS) && tmr_done),
        .din    (mem_dq_in),
        .valid  (rd_valid),
        .data   (rd_data)
    );

    // Next state and phase-timer load.
    always_comb begin
        st_d     = st_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (st_q)
            ST_IDLE: begin
                if (req_valid) begin
                    tmr_load = 1'b1;
                    if (req_write) begin
                        st_d    = ST_WR_SETUP;
                        tmr_val = CNT_W'(N_SU - 1);
                    end else begin
                        st_d    = ST_RD_ACCESS;
                        tmr_val = CNT_W'(N_RD - 1);
                    end
                end
            end
            ST_WR_SETUP: begin
                if (tmr_done) begin
                    st_d     = ST_WR_PULSE;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(N_WP - 1);
                end
            end
            ST_WR_PULSE: begin
                if (tmr_done) begin
                    st_d     = ST_WR_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(N_WH - 1);
                end
            end
            ST_WR_HOLD: begin
                if (tmr_done)
                    st_d = ST_IDLE;
            end
            ST_RD_ACCESS: begin
                if (tmr_done) begin
                    st_d     = ST_RD_TURN;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(N_TA - 1);
                end
            end
            ST_RD_TURN: begin
                if (tmr_done)
                    st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= ST_IDLE;
        else
            st_q <= st_d;
    end

    // Strobe decode of the upcoming state, registered so the pins are glitch free.
    assign nxt_sel = (st_d == ST_WR_SETUP) || (st_d == ST_WR_PULSE) ||
                     (st_d == ST_WR_HOLD)  || (st_d == ST_RD_ACCESS);
    assign nxt_we  = (st_d == ST_WR_PULSE);
    assign nxt_oe  = (st_d == ST_RD_ACCESS);
    assign nxt_drv = (st_d == ST_WR_PULSE) || (st_d == ST_WR_HOLD);

    // Output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_sel_n  <= 1'b1;
            mem_sel_hi <= 1'b0;
            mem_we_n   <= 1'b1;
            mem_oe_n   <= 1'b1;
            mem_dq_drv <= 1'b0;
            mem_addr   <= '0;
            mem_dq_out <= '0;
        end else begin
            mem_sel_n  <= !nxt_sel;
            mem_sel_hi <= nxt_sel;
            mem_we_n   <= !nxt_we;
            mem_oe_n   <= !nxt_oe;
            mem_dq_drv <= nxt_drv;
            if (accept) begin
                mem_addr <= req_addr;
                if (req_write)
                    mem_dq_out <= req_wdata;
            end
        end
    end
endmodule

module sram_strobe_ctrl_chk #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8,
    parameter int N_WP   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_sel_n,
    input logic              mem_sel_hi,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic              mem_dq_drv
);
    logic [7:0] we_low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            we_low_cnt <= '0;
        else if (!mem_we_n) begin
            if (we_low_cnt != 8'hFF)
                we_low_cnt <= we_low_cnt + 8'd1;
        end else
            we_low_cnt <= '0;
    end

    assert_busy_after_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    assert_idle_deselected_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> mem_sel_n && !mem_sel_hi);

    assert_we_inside_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_sel_n && mem_sel_hi && mem_oe_n);

    assert_we_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (int'(we_low_cnt) >= N_WP));

    assert_drive_covers_we_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_dq_drv);

    assert_drive_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> mem_dq_drv);

    assert_no_drive_with_oe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_drv |-> mem_oe_n);

    assert_addr_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_sel_n && !$past(mem_sel_n) |-> $stable(mem_addr));

    assert_wdata_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_drv && $past(mem_dq_drv) |-> $stable(mem_dq_out));

    assert_rdvalid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    assert_rdvalid_after_oe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> $rose(mem_oe_n));

    assert_turnaround_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |=> mem_sel_n && !mem_dq_drv);
endmodule

bind sram_strobe_ctrl sram_strobe_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .N_WP   (N_WP)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rd_valid   (rd_valid),
    .mem_addr   (mem_addr),
    .mem_sel_n  (mem_sel_n),
    .mem_sel_hi (mem_sel_hi),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_drv (mem_dq_drv)
);

// File: tb/sram_strobe_ctrl_bench.sv
`timescale 1ns/1ps
module sram_strobe_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [12:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rd_valid;
    logic [7:0]  rd_data;
    logic [12:0] mem_addr;
    logic        mem_sel_n, mem_sel_hi, mem_we_n, mem_oe_n, mem_dq_drv;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = 8'hA5;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    always #4 clk = ~clk;

    sram_strobe_ctrl u_sram_strobe_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_sel_hi(mem_sel_hi),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_dq_out(mem_dq_out), .mem_dq_drv(mem_dq_drv), .mem_dq_in(mem_dq_in)
    );

    function automatic int cyc(input int t_ns);
        int n;
        n = (t_ns + 7) / 8;
        return (n < 1) ? 1 : n;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int E_WP = mx(mx(cyc(12), cyc(10)), mx(cyc(20) - 1, 1));
    localparam int E_WR = 1 + E_WP + mx(1, cyc(25) - 1 - E_WP);
    localparam int E_RD = mx(cyc(25), cyc(9));
    localparam int E_TA = cyc(9);

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // ---------------- behavioural memory with timing checks ----------------
    logic [7:0] store [int];
    logic [7:0] expv  [int];
    realtime t_addr = 0, t_sel = 0, t_oe = 0, t_wst = 0, t_drv = 0, t_moff = -100;
    bit p_sel = 0, p_wact = 0, p_drv = 0, p_oe = 0, p_mdrive = 0;
    logic [12:0] p_addr = '0;
    logic [7:0]  p_dout = '0;

    function automatic logic [7:0] rd_store(input int a);
        return store.exists(a) ? store[a] : 8'h00;
    endfunction

    task automatic model_step();
        bit sel, wact, oe, mdrive;
        realtime now;
        now    = $realtime;
        sel    = !mem_sel_n && mem_sel_hi;
        wact   = sel && !mem_we_n;
        oe     = !mem_oe_n;
        mdrive = sel && mem_we_n && oe;
        if (rst_n) begin
            if (p_wact && mem_addr != p_addr)
                check(0, "R6", "address moved during write strobe", int'(mem_addr), int'(p_addr));
            if (mdrive && mem_dq_drv)
                check(0, "R5", "bus contention", 1, 0);
            if (wact && !p_wact)
                check(!oe, "R4", "output enable low at write start", int'(oe), 0);
            if (mem_dq_drv && !p_drv)
                check((now - t_moff) >= 9.0 && !mdrive, "R5", "drive start after memory release ns",
                      int'(now - t_moff), 9);
            if (p_wact && !wact) begin
                check((now - t_wst) >= 12.0, "R4", "write pulse ns", int'(now - t_wst), 12);
                check(p_drv && (now - t_drv) >= 10.0, "R5", "data setup ns", int'(now - t_drv), 10);
                check((now - t_addr) >= 20.0 && (now - t_sel) >= 20.0, "R6", "address valid to write end ns",
                      int'(now - t_addr), 20);
                store[int'(p_addr)] = p_dout;
            end
            if (p_sel && !sel)
                check((now - t_sel) >= 25.0, "R9", "selection window ns", int'(now - t_sel), 25);
        end
        if (mem_addr != p_addr) t_addr = now;
        if (sel && !p_sel) t_sel = now;
        if (oe && !p_oe) t_oe = now;
        if (wact && !p_wact) t_wst = now;
        if ((mem_dq_drv && !p_drv) || (mem_dq_drv && mem_dq_out != p_dout)) t_drv = now;
        if (p_mdrive && !mdrive) t_moff = now;
        if (mdrive) begin
            if ((now - ((t_addr > t_sel) ? t_addr : t_sel)) >= 25.0 && (now - t_oe) >= 9.0)
                mem_dq_in = rd_store(int'(mem_addr));
            else
                mem_dq_in = ~rd_store(int'(mem_addr));
        end else
            mem_dq_in = 8'hA5;
        p_sel = sel; p_wact = wact; p_drv = mem_dq_drv; p_oe = oe; p_mdrive = mdrive;
        p_addr = mem_addr; p_dout = mem_dq_out;
    endtask

    initial begin
        #0.5;
        forever begin
            model_step();
            #1;
        end
    end

    // ---------------- request tasks ----------------
    task automatic issue(input bit wr, input logic [12:0] a, input logic [7:0] d);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (wr) expv[int'(a)] = d;
    endtask

    task automatic do_write(input logic [12:0] a, input logic [7:0] d, input bit timed);
        int k;
        issue(1'b1, a, d);
        k = 1;
        if (timed) check(!req_ready, "R2", "ready low after write taken", int'(req_ready), 0);
        while (!req_ready && k < 50) begin @(negedge clk); k++; end
        if (timed) check(k == E_WR + 1, "R2", "write busy length", k, E_WR + 1);
    endtask

    task automatic do_read(input logic [12:0] a, input bit timed, input string req);
        int k;
        logic [7:0] e;
        e = expv.exists(int'(a)) ? expv[int'(a)] : 8'h00;
        issue(1'b0, a, 8'h00);
        k = 1;
        while (!rd_valid && k < 50) begin @(negedge clk); k++; end
        check(rd_data == e, req, "read data", int'(rd_data), int'(e));
        if (timed) begin
            check(k == E_RD + 1, "R7", "read valid latency", k, E_RD + 1);
            @(negedge clk); k++;
            check(!rd_valid, "R7", "read valid one cycle", int'(rd_valid), 0);
            check(mem_sel_n && !mem_dq_drv, "R8", "turnaround deselected and undriven",
                  int'(mem_sel_n), 1);
            while (!req_ready && k < 50) begin @(negedge clk); k++; end
            check(k == E_RD + E_TA + 1, "R2", "read busy length", k, E_RD + E_TA + 1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            check(0, "R2", "watchdog expired", 0, 1);
            finish_run();
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd7717);
        repeat (3) @(negedge clk);
        // R1 reset state
        check(req_ready == 1'b1, "R1", "ready", int'(req_ready), 1);
        check(mem_sel_n == 1'b1 && mem_sel_hi == 1'b0, "R1", "selects inactive", int'(mem_sel_hi), 0);
        check(mem_we_n == 1'b1, "R1", "write strobe", int'(mem_we_n), 1);
        check(mem_oe_n == 1'b1, "R1", "output enable", int'(mem_oe_n), 1);
        check(mem_dq_drv == 1'b0, "R1", "drive enable", int'(mem_dq_drv), 0);
        check(rd_valid == 1'b0, "R1", "read valid", int'(rd_valid), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // directed corners
        do_write(13'h0000, 8'h5A, 1'b1);
        do_read(13'h0000, 1'b1, "R10");
        do_write(13'h1FFF, 8'hFF, 1'b1);
        do_read(13'h1FFF, 1'b1, "R10");
        do_write(13'h1FFF, 8'h00, 1'b0);
        do_read(13'h1FFF, 1'b0, "R10");
        do_read(13'h0ABC, 1'b0, "R10");
        // read then write back to back, then read: R8 turnaround path
        do_read(13'h0000, 1'b0, "R8");
        do_write(13'h0001, 8'hC3, 1'b0);
        do_read(13'h0001, 1'b1, "R8");
        @(negedge clk);
        check(mem_sel_n && !mem_sel_hi, "R3", "deselected while idle", int'(mem_sel_hi), 0);

        // seeded random mix
        for (int i = 0; i < 400; i++) begin
            logic [12:0] a;
            logic [7:0]  d;
            a = ($urandom % 4 == 0) ? 13'($urandom) : (13'h1FF0 + 13'($urandom % 16));
            d = 8'($urandom);
            if ($urandom % 2 == 1) do_write(a, d, 1'b0);
            else                   do_read(a, 1'b0, "R10");
            if ($urandom % 3 == 0) begin
                @(negedge clk);
                check(mem_sel_n && !mem_sel_hi, "R3", "deselected in gap", int'(mem_sel_hi), 0);
            end
        end
        repeat (4) @(negedge clk);
        done_flag = 1'b1;
        finish_run();
    end
endmodule